// File: doc/BRIEF.md
# Galois LFSR Coarse Cycle Counter

This block counts the coarse part of a clock-divider period with an 11-bit Galois linear-feedback shift register in place of a binary counter. A shift register has no carry chain, so each step is one XOR level deep whatever the width. The price is that software cannot write a plain count. It must instead pick a start state whose distance from a fixed terminal state is the wanted number of steps.

The terminal state is all ones (0x7FF). Define the state for count index i as the state reached by stepping 2048 - i times from 0x7FF. Loading that state makes the terminal-count output rise after i - 1 enabled steps. The coarse divisor built from this is the index plus 2.

The all-zero state lies outside the sequence. Loading zero gives terminal count at once, and the register then holds at zero. A load strobe takes priority over stepping in the same cycle.

Top module: `galois_coarse_counter`

## Requirements
- R1: While reset is held and after it is released with no load, the state output is 0 and the terminal-count output is 1.
- R2: A load strobe sampled high at a clock edge puts the start-state input on the state output after that edge, and it does so whether step enable is high or low.
- R3: A clock edge with step enable high, load strobe low and a nonzero state shifts the state right by one bit. If the bit shifted out was 1, the shifted value is XORed with 0x500.
- R4: A clock edge with step enable low and load strobe low leaves the state unchanged.
- R5: The terminal-count output is 1 in every cycle in which the state is 0x7FF.
- R6: Once the state is zero it stays zero under step enable until the next load, and the terminal-count output stays 1 the whole time.
- R7: Take the state reached by stepping 2048 - i times from 0x7FF, for an index i from 1 to 2047. After that state is loaded, the terminal-count output is 0 for the first i - 1 enabled steps and is 1 immediately after step i - 1.
- R8: Stepping from any nonzero state never produces zero. Starting from 0x7FF, the state after k steps is the state for index 2048 - k, and the sequence returns to 0x7FF after exactly 2047 steps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| loadStrobe | input | 1 | Loads startState at the clock edge; takes priority over stepping |
| startState | input | 11 | State to load; encodes the count length as a position in the sequence |
| stepEn | input | 1 | Coarse tick; advances the register by one step |
| termCount | output | 1 | High while the state is the terminal state or zero |
| stateOut | output | 11 | Current register state |

## Verification
A load or a step changes stateOut one clock edge after the edge that samples it, because the state is a single register. termCount is decoded from that register with no extra stage, so it changes in the same cycle as stateOut. The bench drives inputs on the falling edge and samples on the next falling edge, which places each sample exactly one rising edge after its stimulus. In the index sweeps, the bench counts falling edges between the load and the first cycle in which termCount is high, and compares that count with i - 1.

// File: rtl/galois_cnt_pkg.sv
package galois_cnt_pkg;
  localparam int unsigned CNT_WIDTH = 11;
  localparam logic [CNT_WIDTH:0] CNT_POLY = 12'hA01;

  typedef struct packed {
    logic load;
    logic step;
  } ctrlStrobes_t;
endpackage

// File: rtl/galois_cnt_ctrl.sv
module galois_cnt_ctrl
  import galois_cnt_pkg::*;
(
  input  logic         loadStrobe,
  input  logic         stepEn,
  input  logic         stateZero,
  output ctrlStrobes_t strobes
);
  // A load wins over a step; the zero state is parked and never advanced.
  always_comb begin
    strobes.load = loadStrobe;
    strobes.step = stepEn && !loadStrobe && !stateZero;
  end
endmodule

// File: rtl/galois_cnt_datapath.sv
module galois_cnt_datapath
  import galois_cnt_pkg::*;
#(
  parameter int unsigned WIDTH = CNT_WIDTH,
  parameter logic [WIDTH:0] POLY = CNT_POLY
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrobes_t     strobes,
  input  logic [WIDTH-1:0] loadValue,
  output logic [WIDTH-1:0] state,
  output logic             isZero,
  output logic             isTerm
);
  localparam logic [WIDTH-1:0] TAP  = POLY[WIDTH:1];
  localparam logic [WIDTH-1:0] TERM = '1;

  logic [WIDTH-1:0] stepped;

  // One XOR per bit: bit b takes the bit above it, flipped by the tap when
  // the bit leaving at the bottom is 1.
  genvar b;
  generate
    for (b = 0; b < WIDTH; b++) begin : g_bit
      if (b == WIDTH - 1) begin : g_top
        assign stepped[b] = TAP[b] & state[0];
      end else begin : g_mid
        assign stepped[b] = state[b+1] ^ (TAP[b] & state[0]);
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             state <= '0;
    else if (strobes.load) state <= loadValue;
    else if (strobes.step) state <= stepped;
  end

  assign isZero = (state == '0);
  assign isTerm = (state == TERM);

  assert_load_R2: assert property (@(posedge clk) disable iff (!rstN)
    strobes.load |=> state == $past(loadValue));

  assert_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.load && !strobes.step) |=> $stable(state));

  assert_zero_park_R6: assert property (@(posedge clk) disable iff (!rstN)
    (isZero && !strobes.load) |=> isZero);

  assert_never_zero_R8: assert property (@(posedge clk) disable iff (!rstN)
    (!isZero && !strobes.load) |=> !isZero);

  assert_step_moves_R3: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.step && !strobes.load) |=> state != $past(state));
endmodule

// File: rtl/galois_coarse_counter.sv
module galois_coarse_counter
  import galois_cnt_pkg::*;
#(
  parameter int unsigned WIDTH = CNT_WIDTH,
  parameter logic [WIDTH:0] POLY = CNT_POLY
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             loadStrobe,
  input  logic [WIDTH-1:0] startState,
  input  logic             stepEn,
  output logic             termCount,
  output logic [WIDTH-1:0] stateOut
);
  ctrlStrobes_t strobes;
  logic         stateZero;
  logic         stateTerm;

  galois_cnt_ctrl u_ctrl (
    .loadStrobe (loadStrobe),
    .stepEn     (stepEn),
    .stateZero  (stateZero),
    .strobes    (strobes)
  );

  galois_cnt_datapath #(.WIDTH(WIDTH), .POLY(POLY)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .loadValue (startState),
    .state     (stateOut),
    .isZero    (stateZero),
    .isTerm    (stateTerm)
  );

  assign termCount = stateTerm || stateZero;

  assert_term_flag_R5: assert property (@(posedge clk) disable iff (!rstN)
    (loadStrobe && startState == '1) |=> termCount);
endmodule

// File: tb/galois_coarse_counter_tb.sv
module galois_coarse_counter_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        loadStrobe = 1'b0;
  logic [10:0] startState = '0;
  logic        stepEn = 1'b0;
  logic        termCount;
  logic [10:0] stateOut;

  int vecCount  = 0;
  int failCount = 0;
  int cycles    = 0;
  bit done      = 1'b0;
  logic [10:0] fwdTbl [2048];

  galois_coarse_counter dut_i (
    .clk(clk), .rstN(rstN), .loadStrobe(loadStrobe), .startState(startState),
    .stepEn(stepEn), .termCount(termCount), .stateOut(stateOut)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [10:0] mdlStep(input logic [10:0] s);
    return (s >> 1) ^ (s[0] ? 11'h500 : 11'h000);
  endfunction

  task automatic check(input string req, input logic [10:0] act, input logic [10:0] exp);
    vecCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s: actual 0x%03h expected 0x%03h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic loadState(input logic [10:0] v, input logic se);
    loadStrobe = 1'b1; startState = v; stepEn = se;
    cyc();
    loadStrobe = 1'b0;
  endtask

  task automatic testReset();
    check("R1 state in reset", stateOut, 11'h000);
    check("R1 tc in reset", {10'b0, termCount}, 11'd1);
    rstN = 1'b1;
    cyc(); cyc();
    check("R1 state after reset", stateOut, 11'h000);
    check("R1 tc after reset", {10'b0, termCount}, 11'd1);
  endtask

  task automatic testLoadOverride();
    loadState(11'h123, 1'b1);
    check("R2 load with step high", stateOut, 11'h123);
    stepEn = 1'b0;
    loadState(11'h2A5, 1'b0);
    check("R2 load with step low", stateOut, 11'h2A5);
    check("R5 tc low off terminal", {10'b0, termCount}, 11'd0);
  endtask

  task automatic testStepRule();
    logic [10:0] pats [4] = '{11'h001, 11'h002, 11'h7FF, 11'h400};
    for (int p = 0; p < 4; p++) begin
      loadState(pats[p], 1'b0);
      stepEn = 1'b1;
      cyc();
      stepEn = 1'b0;
      check("R3 single step", stateOut, mdlStep(pats[p]));
    end
  endtask

  task automatic testHold();
    loadState(11'h0F0, 1'b0);
    stepEn = 1'b0;
    cyc(); cyc(); cyc();
    check("R4 hold with step low", stateOut, 11'h0F0);
  endtask

  task automatic testZero();
    loadState(11'h000, 1'b0);
    check("R6 tc at zero", {10'b0, termCount}, 11'd1);
    stepEn = 1'b1;
    for (int k = 0; k < 5; k++) cyc();
    check("R6 zero parked", stateOut, 11'h000);
    check("R6 tc stays", {10'b0, termCount}, 11'd1);
    stepEn = 1'b0;
  endtask

  task automatic testPeriod();
    bit bad = 1'b0;
    loadState(11'h7FF, 1'b0);
    check("R5 tc at terminal", {10'b0, termCount}, 11'd1);
    stepEn = 1'b1;
    for (int k = 1; k <= 2047; k++) begin
      cyc();
      if (stateOut !== fwdTbl[2048 - k] && !bad) begin
        bad = 1'b1;
        check("R8 sequence position", stateOut, fwdTbl[2048 - k]);
      end
      if (k < 2047 && (stateOut == 11'h000 || termCount) && !bad) begin
        bad = 1'b1;
        check("R8 no zero or early tc", {10'b0, termCount}, 11'd0);
      end
    end
    stepEn = 1'b0;
    check("R8 period 2047", stateOut, 11'h7FF);
    check("R5 tc after period", {10'b0, termCount}, 11'd1);
  endtask

  task automatic testIndex(input int i);
    int steps;
    loadState(fwdTbl[i], 1'b1);
    check("R7 loaded index state", stateOut, fwdTbl[i]);
    stepEn = 1'b1;
    steps = 0;
    while (!termCount && steps < 4096) begin
      cyc();
      steps++;
    end
    stepEn = 1'b0;
    check("R7 steps to terminal", steps[10:0], 11'(i - 1));
  endtask

  initial begin
    logic [10:0] s = 11'h7FF;
    for (int i = 2047; i > 0; i--) begin
      s = mdlStep(s);
      fwdTbl[i] = s;
    end
    fwdTbl[0] = 11'h000;
    cyc(); cyc();
    testReset();
    testLoadOverride();
    testStepRule();
    testHold();
    testZero();
    testPeriod();
    for (int i = 1; i <= 24; i++) testIndex(i);
    testIndex(100);
    testIndex(512);
    testIndex(1023);
    testIndex(1024);
    testIndex(2000);
    testIndex(2047);
    if (!done) begin
      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", vecCount, failCount);
      $finish;
    end
  end

  initial begin
    while (cycles < WATCHDOG) begin
      @(posedge clk);
      cycles++;
    end
    if (!done) begin
      done = 1'b1;
      vecCount++;
      failCount++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
      $display("  == %0d vectors applied, %0d miscompares ==", vecCount, failCount);
      $finish;
    end
  end
endmodule